// File: doc/BRIEF.md
# Scheduled Four-Tap FIR Datapath

This block computes a four-tap finite impulse response filter, y = a0·x + a1·x@1 + a2·x@2 + a3·x@3, where x@k is the sample taken k sample periods before the current one. It does not use four multipliers and an adder tree. Two multipliers and a single adder are reused under a fixed four-cycle schedule. A register sits between every pair of execution units, so no combinational path chains one unit into another.

The four coefficients are written through a small indexed port while the block is idle. A sample is presented with a one-cycle strobe. Three cycles after the strobe the block drives the result together with a one-cycle valid pulse. The output comes straight from the shared adder, with no extra register stage. When the result is delivered, the history of past samples shifts by one place. A new sample can be accepted in the very next cycle, which gives a sample period of four clocks.

Top module: `fir4_sched_top`

## Requirements
- R1: While reset is held, out_valid and out_data are 0. Reset clears the sample history, so the first result after reset equals a0·x.
- R2: When the block is idle and in_valid is low, a coefficient write (coef_we high) stores coef_val into the coefficient selected by coef_idx. Index 0 selects a0, 1 selects a1, 2 selects a2 and 3 selects a3. Coefficients and samples are 16-bit two's complement.
- R3: A coefficient write is ignored while a sample is being computed. It is also ignored in the same cycle that a sample is accepted. The result always uses the coefficients in place at acceptance.
- R4: A sample is accepted when in_valid is high and the block is idle. out_valid then goes high for exactly one cycle, in the third cycle after the acceptance cycle.
- R5: The result equals a0·x + a1·x@1 + a2·x@2 + a3·x@3. After each result, x@3, x@2 and x@1 take the values of x@2, x@1 and x.
- R6: in_valid is ignored while a computation is in progress. It neither restarts the schedule nor changes the history.
- R7: A new sample is accepted in the cycle right after out_valid. If in_valid is held high, one sample is taken every four cycles.
- R8: out_data is a 34-bit two's-complement value carried at full precision. All-extreme operands give exactly +2^32 and -2^32+2^17.
- R9: out_data is 0 in every cycle where out_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| coef_we | input | 1 | Coefficient write strobe |
| coef_idx | input | 2 | Coefficient select (0 = a0 … 3 = a3) |
| coef_val | input | 16 | Coefficient value, signed |
| in_valid | input | 1 | Sample strobe |
| in_sample | input | 16 | Sample value, signed |
| out_valid | output | 1 | One-cycle result strobe |
| out_data | output | 34 | Filter result, signed |

## Verification
The first sample after reset isolates the a0 path, because the history is still zero. A few spaced samples with distinct small coefficients then show whether each tap is paired with the right history slot. Samples arrive at three spacings: with idle gaps, back to back at the cycle after the result, and with in_valid held high throughout. These separate the correct four-cycle period from schedules that restart or skip samples. Coefficient writes are attempted mid-computation and in the acceptance cycle to expose leaks into the running result. All-extreme operands check that the result keeps full precision at both signs.

// File: rtl/fir4_pkg.sv
package fir4_pkg;

    // Position within the four-cycle sample period.
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,   // waiting; acceptance cycle = schedule cycle 1
        PH_MUL2 = 2'd1,   // schedule cycle 2
        PH_SUM2 = 2'd2,   // schedule cycle 3
        PH_OUT  = 2'd3    // schedule cycle 4, result on the port
    } phase_e;

endpackage

// File: rtl/fir4_ctrl.sv
module fir4_ctrl
    import fir4_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   in_valid,
    output phase_e phase,
    output logic   accept,
    output logic   busy
);

    phase_e phase_d, phase_q;

    always_comb begin
        phase_d = phase_q;
        accept  = 1'b0;
        unique case (phase_q)
            PH_IDLE: begin
                if (in_valid) begin
                    accept  = 1'b1;
                    phase_d = PH_MUL2;
                end
            end
            PH_MUL2: phase_d = PH_SUM2;
            PH_SUM2: phase_d = PH_OUT;
            PH_OUT:  phase_d = PH_IDLE;
            default: phase_d = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= PH_IDLE;
        else        phase_q <= phase_d;
    end

    assign phase = phase_q;
    assign busy  = (phase_q != PH_IDLE);

endmodule

// File: rtl/fir4_mult.sv
module fir4_mult #(
    parameter int AW = 16,
    parameter int BW = 16,
    localparam int PW = AW + BW
) (
    input  logic [AW-1:0] op_a,
    input  logic [BW-1:0] op_b,
    output logic [PW-1:0] prod
);

    logic signed [PW-1:0] ext_a, ext_b;

    always_comb begin
        ext_a = PW'($signed(op_a));
        ext_b = PW'($signed(op_b));
        prod  = ext_a * ext_b;
    end

endmodule

// File: rtl/fir4_add.sv
module fir4_add #(
    parameter int W = 34
) (
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    output logic [W-1:0] sum
);

    assign sum = op_a + op_b;

endmodule

// File: rtl/fir4_sched_top.sv
module fir4_sched_top
    import fir4_pkg::*;
#(
    parameter int DW = 16,
    parameter int CW = 16,
    localparam int PW = DW + CW,
    localparam int AW = PW + 2,
    localparam int NTAP = 4,
    localparam int NHIST = NTAP - 1,
    localparam int IW = $clog2(NTAP)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          coef_we,
    input  logic [IW-1:0] coef_idx,
    input  logic [CW-1:0] coef_val,
    input  logic          in_valid,
    input  logic [DW-1:0] in_sample,
    output logic          out_valid,
    output logic [AW-1:0] out_data
);

    typedef struct packed {
        logic [DW-1:0]             xnew;  // sample of this period
        logic [NHIST-1:0][DW-1:0]  hist;  // [0]=x@1, [1]=x@2, [2]=x@3
        logic [NTAP-1:0][CW-1:0]   coef;  // [k]=ak
        logic [PW-1:0]             p1;
        logic [PW-1:0]             p2;
        logic [AW-1:0]             s1;
        logic [AW-1:0]             s2;
    } dp_t;

    dp_t dp_d, dp_q;

    phase_e phase;
    logic   accept;
    logic   busy_w;

    fir4_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .phase    (phase),
        .accept   (accept),
        .busy     (busy_w)
    );

    // Operand selection for the two shared multipliers.
    logic [DW-1:0] m_a [2];
    logic [CW-1:0] m_b [2];
    logic [PW-1:0] m_p [2];

    always_comb begin
        if (phase == PH_IDLE) begin
            m_a[0] = dp_q.hist[2]; m_b[0] = dp_q.coef[3];
            m_a[1] = dp_q.hist[1]; m_b[1] = dp_q.coef[2];
        end else begin
            m_a[0] = dp_q.hist[0]; m_b[0] = dp_q.coef[1];
            m_a[1] = dp_q.xnew;    m_b[1] = dp_q.coef[0];
        end
    end

    for (genvar g = 0; g < 2; g++) begin : g_mul
        fir4_mult #(.AW(DW), .BW(CW)) u_mul (
            .op_a (m_a[g]),
            .op_b (m_b[g]),
            .prod (m_p[g])
        );
    end

    // Shared adder: products in cycles 2 and 3, partial sums in cycle 4.
    logic [AW-1:0] add_a, add_b, add_s;

    always_comb begin
        if (phase == PH_OUT) begin
            add_a = dp_q.s1;
            add_b = dp_q.s2;
        end else begin
            add_a = AW'($signed(dp_q.p1));
            add_b = AW'($signed(dp_q.p2));
        end
    end

    fir4_add #(.W(AW)) u_add (
        .op_a (add_a),
        .op_b (add_b),
        .sum  (add_s)
    );

    always_comb begin
        dp_d = dp_q;
        unique case (phase)
            PH_IDLE: begin
                if (accept) begin
                    dp_d.xnew = in_sample;
                    dp_d.p1   = m_p[0];
                    dp_d.p2   = m_p[1];
                end else if (coef_we) begin
                    dp_d.coef[coef_idx] = coef_val;
                end
            end
            PH_MUL2: begin
                dp_d.s1 = add_s;
                dp_d.p1 = m_p[0];
                dp_d.p2 = m_p[1];
            end
            PH_SUM2: begin
                dp_d.s2 = add_s;
            end
            PH_OUT: begin
                for (int k = NHIST - 1; k > 0; k--) begin
                    dp_d.hist[k] = dp_q.hist[k-1];
                end
                dp_d.hist[0] = dp_q.xnew;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) dp_q <= '0;
        else        dp_q <= dp_d;
    end

    assign out_valid = (phase == PH_OUT);
    assign out_data  = out_valid ? add_s : '0;

    // Flattened coefficient view for the checker.
    logic [NTAP*CW-1:0] coef_flat;
    assign coef_flat = dp_q.coef;

endmodule

// File: rtl/fir4_sched_chk.sv
module fir4_sched_chk #(
    parameter int AW = 34,
    parameter int CFW = 64
) (
    input logic           clk,
    input logic           rst_n,
    input logic           in_valid,
    input logic           busy,
    input logic           out_valid,
    input logic [AW-1:0]  out_data,
    input logic [CFW-1:0] coef_flat
);

    localparam logic signed [AW-1:0] YMAX = AW'(64'sd4294967296);
    localparam logic signed [AW-1:0] YMIN = AW'(-64'sd4294836224);

    assert_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid && !busy, 3));

    assert_one_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    assert_no_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !out_valid) |=> busy);

    assert_back_to_back_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !busy);

    assert_coef_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy || in_valid) |=> $stable(coef_flat));

    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ($signed(out_data) <= YMAX && $signed(out_data) >= YMIN));

    assert_quiet_output_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (out_data == '0));

endmodule

bind fir4_sched_top fir4_sched_chk #(.AW(AW), .CFW(NTAP*CW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .busy      (busy_w),
    .out_valid (out_valid),
    .out_data  (out_data),
    .coef_flat (coef_flat)
);

// File: tb/tb_fir4_sched_top.sv
module tb_fir4_sched_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        coef_we = 1'b0;
    logic [1:0]  coef_idx = '0;
    logic [15:0] coef_val = '0;
    logic        in_valid = 1'b0;
    logic [15:0] in_sample = '0;
    logic        out_valid;
    logic [33:0] out_data;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    // Behavioural model state
    longint coef_m [4];
    longint hist_m [$];
    longint xcur_m = 0;
    int     busy_m = 0;

    always #2 clk = ~clk;  // 250 MHz

    fir4_sched_top dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .coef_we   (coef_we),
        .coef_idx  (coef_idx),
        .coef_val  (coef_val),
        .in_valid  (in_valid),
        .in_sample (in_sample),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            errors++;
            $display("FAIL watchdog: actual=%0d cycles expected<=20000", cyc);
            finish_run();
        end
    end

    function automatic longint expected_y();
        return coef_m[0] * xcur_m + coef_m[1] * hist_m[0]
             + coef_m[2] * hist_m[1] + coef_m[3] * hist_m[2];
    endfunction

    task automatic compare(input string tag);
        logic   ev;
        longint ey;
        ev = (busy_m == 3);
        ey = ev ? expected_y() : 0;
        checks++;
        if (out_valid !== ev || $signed(out_data) !== ey) begin
            errors++;
            $display("FAIL %s: actual valid=%0b data=%0d expected valid=%0b data=%0d",
                     tag, out_valid, $signed(out_data), ev, ey);
        end
    endtask

    // Drive one cycle of inputs, model the edge, compare at the falling edge.
    task automatic step(input logic v, input int x, input logic we,
                        input int idx, input int cv, input string tag);
        in_valid  = v;
        in_sample = 16'(x);
        coef_we   = we;
        coef_idx  = 2'(idx);
        coef_val  = 16'(cv);
        @(posedge clk);
        if (busy_m == 0) begin
            if (v) begin
                xcur_m = longint'($signed(16'(x)));
                busy_m = 1;
            end else if (we) begin
                coef_m[idx] = longint'($signed(16'(cv)));
            end
        end else if (busy_m == 3) begin
            hist_m.push_front(xcur_m);
            void'(hist_m.pop_back());
            busy_m = 0;
        end else begin
            busy_m++;
        end
        @(negedge clk);
        compare(tag);
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) step(1'b0, 0, 1'b0, 0, 0, tag);
    endtask

    task automatic wcoef(input int idx, input int cv);
        step(1'b0, 0, 1'b1, idx, cv, "R2");
    endtask

    task automatic sample(input int x, input string tag);
        step(1'b1, x, 1'b0, 0, 0, tag);
        idle(3, tag);
    endtask

    initial begin
        for (int k = 0; k < 4; k++) coef_m[k] = 0;
        for (int k = 0; k < 3; k++) hist_m.push_back(0);

        // R1: reset state
        repeat (3) @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || out_data !== '0) begin
            errors++;
            $display("FAIL R1: actual valid=%0b data=%0d expected valid=0 data=0",
                     out_valid, out_data);
        end
        rst_n = 1'b1;
        idle(2, "R9");

        // R2: load distinct coefficients
        wcoef(0, 3); wcoef(1, -5); wcoef(2, 7); wcoef(3, 11);

        // R1: first result after reset uses empty history
        sample(100, "R1");
        idle(2, "R9");
        // R5: history fills, taps paired with right slots
        sample(-20, "R5");
        idle(1, "R5");
        sample(7, "R5");
        sample(1000, "R5");

        // R7: back to back samples via re-strobe in the cycle after out_valid
        sample(-1, "R7");
        sample(2, "R7");
        sample(3, "R7");

        // R6: in_valid held high for several periods
        for (int i = 0; i < 12; i++) step(1'b1, 50 + i, 1'b0, 0, 0, "R6");
        idle(4, "R6");

        // R3: write while busy and in the acceptance cycle
        step(1'b1, 9, 1'b1, 0, 999, "R3");
        step(1'b0, 0, 1'b1, 1, 123, "R3");
        step(1'b0, 0, 1'b1, 2, -77, "R3");
        step(1'b0, 0, 1'b1, 3, 555, "R3");
        idle(1, "R3");
        sample(4, "R3");

        // R8: extreme operands, positive bound
        for (int k = 0; k < 4; k++) wcoef(k, -32768);
        for (int i = 0; i < 4; i++) sample(-32768, "R8");
        // R8: negative bound
        for (int k = 0; k < 4; k++) wcoef(k, 32767);
        for (int i = 0; i < 4; i++) sample(-32768, "R8");
        idle(3, "R9");

        finish_run();
    end

endmodule